// File: doc/BRIEF.md
# Load-Destination Floating-Point Register Renamer

This block renames floating-point registers for a machine where only the targets of loads get fresh physical registers. Each cycle it accepts at most one instruction in program order: an add, a multiply or a load. Both source operands are translated through an architectural-to-physical map. For an arithmetic instruction, the destination also reads the map as it stands. For a load, the destination takes the physical register at the head of a free list. The mapping it displaces is parked in a return queue, tagged with the newly assigned register.

Each completion presents the tag of one finished instruction. When that tag equals the tag at the head of the return queue, the parked register moves to the tail of the free list. Loads must therefore complete in rename order.

The controller has two states. `ST_FILL` follows reset and writes the spare physical registers into the free list, one per cycle, while the input is held off. The transition `fill_done` moves it to `ST_RUN`, where renaming and release proceed. The only way back to `ST_FILL` is reset.

Top module: `ldrn_top`

## Requirements
- R1: After reset the map sends architectural register i to physical register i. The free list is filled with physical registers ARCH_REGS..PHYS_REGS-1 in ascending order, one per cycle. `in_ready` stays low for those PHYS_REGS-ARCH_REGS cycles and is high in the cycle after.
- R2: An accepted load (`in_op` = 2'b10) gets the free-list head as `out_dst` in the same cycle. From the next cycle on, the map sends its destination to that register.
- R3: Sources are translated through the map as it was before any update made in the same cycle.
- R4: An arithmetic instruction (`in_op` = 2'b00 add, 2'b01 mul, 2'b11 treated as arithmetic) reports its current mapping as `out_dst`. It changes neither the map nor the free list.
- R5: A load stalls (`in_ready` low, no state change) while the free list is empty or the return queue holds RETQ_DEPTH entries. This holds even if a release happens in the same cycle.
- R6: In `ST_RUN`, arithmetic instructions are never stalled.
- R7: A completion whose tag equals the return-queue head's tag moves the head's old register to the tail of the free list. Any other completion tag has no effect.
- R8: A release and a load rename in the same cycle both take effect.
- R9: `out_valid` is high exactly when `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_op | input | 2 | 00 add, 01 mul, 10 load, 11 arithmetic |
| in_dst | input | AW | Architectural destination |
| in_src_a | input | AW | Architectural source A |
| in_src_b | input | AW | Architectural source B |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| out_valid | output | 1 | Renamed fields valid |
| out_src_a | output | PW | Physical source A |
| out_src_b | output | PW | Physical source B |
| out_dst | output | PW | Physical destination (the tag for a load) |
| cmp_valid | input | 1 | Completion present |
| cmp_tag | input | PW | Tag of the completing instruction |

## Verification
The hardest state to reach is a full return queue with the free list empty, at the same moment as a completion that matches the head. This is where the stall must hold for one more cycle while the register is freed. The stimulus table gets there by renaming four loads back to back without completions. It then presents a non-matching tag, followed by a stalled load that carries the matching tag. It then checks that the next load receives exactly the released register. A later row combines a release and a rename in one cycle, so the free list is pushed and popped at once.

// File: rtl/ldrn_pkg.sv
package ldrn_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_MUL  = 2'b01,
        OP_LOAD = 2'b10,
        OP_ARX  = 2'b11
    } fop_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } rn_state_e;
endpackage

// File: rtl/ldrn_fifo.sv
module ldrn_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] rd_ptr, wr_ptr;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    p_fifo_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full);
    p_fifo_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/ldrn_map.sv
module ldrn_map #(
    parameter int ARCH = 8,
    parameter int PW   = 4,
    parameter int NRD  = 3,
    localparam int AW  = $clog2(ARCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [PW-1:0]            wr_data,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][PW-1:0]   rd_data
);
    logic [PW-1:0] tbl [ARCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH; i++) tbl[i] <= PW'(i);
        end else if (wr_en) begin
            tbl[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = tbl[rd_addr[g]];
    end

    p_map_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/ldrn_top.sv
module ldrn_top
    import ldrn_pkg::*;
#(
    parameter int ARCH_REGS  = 8,
    parameter int PHYS_REGS  = 12,
    parameter int RETQ_DEPTH = 4,
    localparam int AW    = $clog2(ARCH_REGS),
    localparam int PW    = $clog2(PHYS_REGS),
    localparam int NFREE = PHYS_REGS - ARCH_REGS,
    localparam int FCW   = (NFREE > 1) ? $clog2(NFREE) : 1,
    localparam int FLC   = $clog2(NFREE + 1),
    localparam int RQC   = $clog2(RETQ_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic [AW-1:0] in_dst,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    output logic          in_ready,
    output logic          out_valid,
    output logic [PW-1:0] out_src_a,
    output logic [PW-1:0] out_src_b,
    output logic [PW-1:0] out_dst,
    input  logic          cmp_valid,
    input  logic [PW-1:0] cmp_tag
);
    rn_state_e state, state_nx;
    logic [FCW-1:0] fill_cnt;
    logic           fill_done;

    logic           is_load, acc, ld_acc, release_hit;
    logic           fl_push, fl_pop, fl_empty, fl_full;
    logic [PW-1:0]  fl_din, fl_head;
    logic [FLC-1:0] fl_cnt;
    logic           rq_push, rq_pop, rq_empty, rq_full;
    logic [2*PW-1:0] rq_din, rq_head;
    logic [RQC-1:0] rq_cnt;
    logic [2:0][AW-1:0] mrd_addr;
    logic [2:0][PW-1:0] mrd_data;

    assign is_load     = (fop_e'(in_op) == OP_LOAD);
    assign fill_done   = (fill_cnt == FCW'(NFREE - 1));
    assign release_hit = cmp_valid && !rq_empty && (rq_head[PW-1:0] == cmp_tag);
    assign mrd_addr    = {in_dst, in_src_b, in_src_a};

    // State register and fill counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx = state;
        in_ready = 1'b0;
        fl_push  = 1'b0;
        fl_din   = rq_head[2*PW-1:PW];
        rq_pop   = 1'b0;
        unique case (state)
            ST_FILL: begin
                fl_push = 1'b1;
                fl_din  = PW'(ARCH_REGS) + PW'(fill_cnt);
                if (fill_done) state_nx = ST_RUN;
            end
            ST_RUN: begin
                in_ready = !is_load || (!fl_empty && !rq_full);
                fl_push  = release_hit;
                rq_pop   = release_hit;
            end
        endcase
    end

    assign acc       = in_valid && in_ready;
    assign ld_acc    = acc && is_load;
    assign fl_pop    = ld_acc;
    assign rq_push   = ld_acc;
    assign rq_din    = {mrd_data[2], fl_head};
    assign out_valid = acc;
    assign out_src_a = mrd_data[0];
    assign out_src_b = mrd_data[1];
    assign out_dst   = is_load ? fl_head : mrd_data[2];

    ldrn_map #(.ARCH(ARCH_REGS), .PW(PW), .NRD(3)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ld_acc), .wr_addr(in_dst), .wr_data(fl_head),
        .rd_addr(mrd_addr), .rd_data(mrd_data)
    );

    ldrn_fifo #(.W(PW), .DEPTH(NFREE)) u_free (
        .clk(clk), .rst_n(rst_n),
        .push(fl_push), .din(fl_din), .pop(fl_pop), .dout(fl_head),
        .count(fl_cnt), .empty(fl_empty), .full(fl_full)
    );

    ldrn_fifo #(.W(2*PW), .DEPTH(RETQ_DEPTH)) u_retq (
        .clk(clk), .rst_n(rst_n),
        .push(rq_push), .din(rq_din), .pop(rq_pop), .dout(rq_head),
        .count(rq_cnt), .empty(rq_empty), .full(rq_full)
    );

    p_fill_holds_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !out_valid);
    p_arith_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_valid && !is_load) |-> out_valid);
    p_stall_keeps_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_valid && is_load && !in_ready && !release_hit)
        |=> ($stable(rq_cnt) && $stable(fl_cnt)));
    p_release_refills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (release_hit && !ld_acc) |=> (fl_cnt == $past(fl_cnt) + 1'b1));
    p_release_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_hit |-> !fl_full);
endmodule

// File: tb/sim_ldrn_top.sv
`timescale 1ns/1ps
module sim_ldrn_top;
    localparam int AW = 3;
    localparam int PW = 4;
    localparam int NFREE = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, out_valid, cmp_valid;
    logic [1:0] in_op;
    logic [AW-1:0] in_dst, in_src_a, in_src_b;
    logic [PW-1:0] out_src_a, out_src_b, out_dst, cmp_tag;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ldrn_top u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_ready(in_ready), .out_valid(out_valid),
        .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] op;
        logic [2:0] dst, sa, sb;
        logic       cv;
        logic [3:0] ct;
        logic       rdy;
        logic [3:0] esa, esb, edst;
        logic [3:0] req;
    } vec_t;

    // 2'b10 = load, 2'b00 add, 2'b01 mul
    localparam vec_t VEC [15] = '{
        '{1'b1, 2'd2, 3'd1, 3'd1, 3'd2, 1'b0, 4'd0, 1'b1, 4'd1,  4'd2,  4'd8,  4'd2},
        '{1'b1, 2'd0, 3'd3, 3'd1, 3'd1, 1'b0, 4'd0, 1'b1, 4'd8,  4'd8,  4'd3,  4'd4},
        '{1'b1, 2'd2, 3'd1, 3'd1, 3'd4, 1'b0, 4'd0, 1'b1, 4'd8,  4'd4,  4'd9,  4'd3},
        '{1'b1, 2'd1, 3'd5, 3'd1, 3'd3, 1'b0, 4'd0, 1'b1, 4'd9,  4'd3,  4'd5,  4'd4},
        '{1'b1, 2'd2, 3'd2, 3'd2, 3'd2, 1'b1, 4'd9, 1'b1, 4'd2,  4'd2,  4'd10, 4'd7},
        '{1'b1, 2'd2, 3'd3, 3'd3, 3'd3, 1'b0, 4'd0, 1'b1, 4'd3,  4'd3,  4'd11, 4'd2},
        '{1'b1, 2'd2, 3'd4, 3'd4, 3'd4, 1'b0, 4'd0, 1'b0, 4'd0,  4'd0,  4'd0,  4'd5},
        '{1'b1, 2'd0, 3'd6, 3'd2, 3'd1, 1'b0, 4'd0, 1'b1, 4'd10, 4'd9,  4'd6,  4'd6},
        '{1'b0, 2'd2, 3'd4, 3'd4, 3'd4, 1'b1, 4'd9, 1'b0, 4'd0,  4'd0,  4'd0,  4'd7},
        '{1'b1, 2'd2, 3'd4, 3'd4, 3'd4, 1'b1, 4'd8, 1'b0, 4'd0,  4'd0,  4'd0,  4'd5},
        '{1'b1, 2'd2, 3'd4, 3'd4, 3'd0, 1'b0, 4'd0, 1'b1, 4'd4,  4'd0,  4'd1,  4'd7},
        '{1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 1'b1, 4'd9, 1'b1, 4'd0,  4'd0,  4'd0,  4'd9},
        '{1'b1, 2'd2, 3'd5, 3'd5, 3'd1, 1'b1, 4'd10,1'b1, 4'd5,  4'd9,  4'd8,  4'd8},
        '{1'b1, 2'd2, 3'd7, 3'd7, 3'd5, 1'b0, 4'd0, 1'b1, 4'd7,  4'd8,  4'd2,  4'd8},
        '{1'b1, 2'd0, 3'd0, 3'd4, 3'd4, 1'b0, 4'd0, 1'b1, 4'd1,  4'd1,  4'd0,  4'd3}
    };

    function automatic string rname(input int r);
        case (r)
            1: return "R1"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; in_op = 2'd0; in_dst = '0;
        in_src_a = '0; in_src_b = '0; cmp_valid = 1'b0; cmp_tag = '0;
    endtask

    // Reset, then walk the fill; R1 timing checked on the way
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1", "ready at fill start", int'(in_ready), 0);
        repeat (NFREE - 1) @(posedge clk);
        @(negedge clk);
        #1 check("R1", "ready before fill end", int'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        #1 check("R1", "ready after fill", int'(in_ready), 1);
    endtask

    initial begin
        #100000;
        n_bad++;
        n_cmp++;
        $display("FAIL R9 watchdog: actual 1 expected 0");
        report();
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        do_reset();

        for (int i = 0; i < 15; i++) begin
            vec_t t;
            t = VEC[i];
            in_valid = t.v; in_op = t.op; in_dst = t.dst;
            in_src_a = t.sa; in_src_b = t.sb;
            cmp_valid = t.cv; cmp_tag = t.ct;
            #1;
            check(rname(int'(t.req)), $sformatf("row %0d ready", i), int'(in_ready), int'(t.rdy));
            check("R9", $sformatf("row %0d out_valid", i), int'(out_valid), int'(t.v && t.rdy));
            if (t.v && t.rdy) begin
                check("R3", $sformatf("row %0d src_a", i), int'(out_src_a), int'(t.esa));
                check("R3", $sformatf("row %0d src_b", i), int'(out_src_b), int'(t.esb));
                check(rname(int'(t.req)), $sformatf("row %0d dst", i), int'(out_dst), int'(t.edst));
            end
            @(negedge clk);
        end
        idle_inputs();

        // Reset mid-run: identity map and fresh free list (R1)
        do_reset();
        in_valid = 1'b1; in_op = 2'd1; in_dst = 3'd7; in_src_a = 3'd1; in_src_b = 3'd5;
        #1;
        check("R1", "identity src_a", int'(out_src_a), 1);
        check("R1", "identity src_b", int'(out_src_b), 5);
        check("R4", "mul dst mapping", int'(out_dst), 7);
        @(negedge clk);
        in_op = 2'd3; in_dst = 3'd2;
        #1;
        check("R4", "op 11 arithmetic dst", int'(out_dst), 2);
        @(negedge clk);
        in_op = 2'd2; in_dst = 3'd7; in_src_a = 3'd7;
        #1;
        check("R1", "first free register", int'(out_dst), 8);
        check("R3", "load src before own update", int'(out_src_a), 7);
        @(negedge clk);
        in_op = 2'd0; in_dst = 3'd0; in_src_a = 3'd7; in_src_b = 3'd7;
        #1;
        check("R2", "map updated after load", int'(out_src_a), 8);
        @(negedge clk);
        in_op = 2'd2; in_dst = 3'd6;
        #1;
        check("R4", "arith took no free register", int'(out_dst), 9);
        @(negedge clk);
        idle_inputs();
        report();
    end
endmodule